// File: doc/BRIEF.md
# Packet Header Trace Filter

This block watches the header of every packet that enters one switch port and tests its leading 128 bits against four programmable compare values. Each value comes with its own bit mask. When any value matches, the packet is marked for an extra copy to a configured trace port, and it still goes to its normal destination. A filter mode can also be switched on. In that mode a packet that matches none of the values is taken off its normal route.

Header data arrives as a valid/ready word stream. A start-of-packet flag and a last-beat flag travel with each beat. The block never applies back-pressure: `hdr_ready` rises on the first clock after reset and then stays high. A beat is consumed on every cycle in which `hdr_valid` and `hdr_ready` are both high. The upstream may drop `hdr_valid` between beats for as long as it likes.

For each packet the block produces a one-cycle result pulse. Alongside the pulse it gives the per-value match flags, the trace-copy and route-drop decisions, and a port-write request. Each compare value also keeps its own saturating hit counter.

Top module: `trace_filter_port`

## Requirements
- R1: `hdr_ready` is low during reset and high in every cycle after it. A beat with `hdr_sop`=1 starts a packet, and its bit WORD_W-1 is header bit 1. Each later beat continues the header in most-significant-first order.
- R2: Compare value i occupies `cmp_value[i*128 +: 128]`. Bit i*128+127 is compared with header bit 1 and bit i*128+0 with header bit 128. `cmp_mask` uses exactly the same layout.
- R3: A mask bit of 1 makes its header bit take part in the comparison and a 0 makes it a don't-care. A value whose 128 mask bits are all zero never matches.
- R4: `res_valid` pulses for one cycle, one clock after the beat that completes header bit 128 is accepted. `match_vec[i]` gives the result for value i, and several bits may be set together. All result outputs hold their value until the next pulse.
- R5: A packet whose last beat comes before bit 128 still gives a result pulse, with no match. Beats after the 128-bit window give no further result. A new start-of-packet beat abandons a packet that has not yet finished.
- R6: `trace_copy` is 1 in a result when `trace_enable` is 1 and at least one value matched. Otherwise it is 0.
- R7: `route_drop` is 1 in a result exactly when `filter_enable` is 1 and no value matched. A matching packet is never dropped.
- R8: `pw_req` pulses together with `res_valid` only when `pw_enable` and `trace_enable` are both 1 and a value matched.
- R9: `hit_count[i*CNT_W +: CNT_W]` is cleared to zero by reset. It rises by one for each result whose `match_vec[i]` is 1, and it stays at all-ones once it gets there.
- R10: `trace_port` loads `trace_port_sel` only in cycles where `trace_enable` is 0. While tracing is enabled it keeps its value. Its reset value is 0.
- R11: When several values match the same packet, every matching value's flag is set and every matching value's counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header beat valid |
| hdr_ready | output | 1 | Block ready to accept a beat |
| hdr_sop | input | 1 | Beat is the first of a packet |
| hdr_last | input | 1 | Beat is the last of a packet |
| hdr_data | input | WORD_W | Header beat, most significant bit first |
| cmp_value | input | NUM_CMP*HDR_W | Packed compare values |
| cmp_mask | input | NUM_CMP*HDR_W | Packed compare masks |
| trace_enable | input | 1 | Tracing on |
| trace_port_sel | input | PORT_W | Requested trace port number |
| pw_enable | input | 1 | Port-write on trace match |
| filter_enable | input | 1 | Drop non-matching packets from normal route |
| res_valid | output | 1 | One-cycle result pulse |
| match_vec | output | NUM_CMP | Per-value match flags |
| trace_copy | output | 1 | Send a copy to the trace port |
| trace_port | output | PORT_W | Trace port in effect |
| route_drop | output | 1 | Suppress normal routing |
| pw_req | output | 1 | Port-write request pulse |
| hit_count | output | NUM_CMP*CNT_W | Packed saturating hit counters |

## Verification
The hardest state to reach is a hit counter sitting at its ceiling while more matches keep arriving. With 32-bit counters that would take about four billion packets. The bench therefore builds the block with a 3-bit counter width and sends one two-value header repeatedly, so both counters reach all-ones and are then pushed further. Abandoned packets are also hard to reach from the ports. They are created with a start-of-packet beat inserted mid-header, and with header beats sent after the window has closed.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE,
    CAP_FILL,
    CAP_SKIP
  } cap_state_e;
endpackage

// File: rtl/trace_hdr_capture.sv
module trace_hdr_capture
  import trace_pkg::*;
#(
  parameter int HDR_W  = 128,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_ok,
  input  logic              beat_sop,
  input  logic              beat_last,
  input  logic [WORD_W-1:0] beat_data,
  output logic [HDR_W-1:0]  win,
  output logic              win_full,
  output logic              pkt_short
);
  localparam int NBEAT = HDR_W / WORD_W;
  localparam int CW    = $clog2(NBEAT + 1);

  cap_state_e      st;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   next_cnt;
  logic            take;

  always_comb begin
    next_cnt = beat_sop ? CW'(1) : cnt + CW'(1);
    take     = beat_ok && (beat_sop || st == CAP_FILL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= CAP_IDLE;
      cnt       <= '0;
      win       <= '0;
      win_full  <= 1'b0;
      pkt_short <= 1'b0;
    end else begin
      win_full  <= 1'b0;
      pkt_short <= 1'b0;
      if (take) begin
        win <= (win << WORD_W) | HDR_W'(beat_data);
        cnt <= next_cnt;
        if (next_cnt == CW'(NBEAT)) begin
          win_full <= 1'b1;
          st       <= beat_last ? CAP_IDLE : CAP_SKIP;
        end else if (beat_last) begin
          pkt_short <= 1'b1;
          st        <= CAP_IDLE;
        end else begin
          st <= CAP_FILL;
        end
      end else if (beat_ok && st == CAP_SKIP && beat_last) begin
        st <= CAP_IDLE;
      end
    end
  end
endmodule

// File: rtl/trace_masked_match.sv
module trace_masked_match #(
  parameter int HDR_W = 128
) (
  input  logic [HDR_W-1:0] win,
  input  logic [HDR_W-1:0] val,
  input  logic [HDR_W-1:0] mask,
  output logic             hit
);
  always_comb begin
    hit = (|mask) && (((win ^ val) & mask) == '0);
  end
endmodule

// File: rtl/trace_sat_counter.sv
module trace_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && count != '1) begin
      count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/trace_filter_port.sv
module trace_filter_port #(
  parameter int NUM_CMP = 4,
  parameter int HDR_W   = 128,
  parameter int WORD_W  = 32,
  parameter int CNT_W   = 32,
  parameter int PORT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hdr_valid,
  output logic                       hdr_ready,
  input  logic                       hdr_sop,
  input  logic                       hdr_last,
  input  logic [WORD_W-1:0]          hdr_data,
  input  logic [NUM_CMP*HDR_W-1:0]   cmp_value,
  input  logic [NUM_CMP*HDR_W-1:0]   cmp_mask,
  input  logic                       trace_enable,
  input  logic [PORT_W-1:0]          trace_port_sel,
  input  logic                       pw_enable,
  input  logic                       filter_enable,
  output logic                       res_valid,
  output logic [NUM_CMP-1:0]         match_vec,
  output logic                       trace_copy,
  output logic [PORT_W-1:0]          trace_port,
  output logic                       route_drop,
  output logic                       pw_req,
  output logic [NUM_CMP*CNT_W-1:0]   hit_count
);
  logic [HDR_W-1:0]   win;
  logic               win_full;
  logic               pkt_short;
  logic [NUM_CMP-1:0] hits;
  logic [NUM_CMP-1:0] outcome;
  logic               decide;
  logic               any_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) hdr_ready <= 1'b0;
    else        hdr_ready <= 1'b1;
  end

  trace_hdr_capture #(.HDR_W(HDR_W), .WORD_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_ok   (hdr_valid && hdr_ready),
    .beat_sop  (hdr_sop),
    .beat_last (hdr_last),
    .beat_data (hdr_data),
    .win       (win),
    .win_full  (win_full),
    .pkt_short (pkt_short)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    trace_masked_match #(.HDR_W(HDR_W)) u_match (
      .win  (win),
      .val  (cmp_value[i*HDR_W +: HDR_W]),
      .mask (cmp_mask[i*HDR_W +: HDR_W]),
      .hit  (hits[i])
    );
    trace_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (win_full && hits[i]),
      .count (hit_count[i*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    decide  = win_full || pkt_short;
    outcome = win_full ? hits : '0;
    any_hit = |outcome;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      match_vec  <= '0;
      trace_copy <= 1'b0;
      route_drop <= 1'b0;
      pw_req     <= 1'b0;
    end else begin
      res_valid <= decide;
      pw_req    <= decide && any_hit && trace_enable && pw_enable;
      if (decide) begin
        match_vec  <= outcome;
        trace_copy <= trace_enable && any_hit;
        route_drop <= filter_enable && !any_hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             trace_port <= '0;
    else if (!trace_enable) trace_port <= trace_port_sel;
  end
endmodule

// File: rtl/trace_filter_chk.sv
module trace_filter_chk #(
  parameter int NUM_CMP = 4,
  parameter int CNT_W   = 32,
  parameter int PORT_W  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     hdr_ready,
  input logic                     trace_enable,
  input logic                     res_valid,
  input logic [NUM_CMP-1:0]       match_vec,
  input logic                     trace_copy,
  input logic [PORT_W-1:0]        trace_port,
  input logic                     route_drop,
  input logic                     pw_req,
  input logic [NUM_CMP*CNT_W-1:0] hit_count
);
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> hdr_ready);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(match_vec));

  p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trace_copy |-> (match_vec != '0));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    route_drop |-> (match_vec == '0));

  p_pw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pw_req |-> (res_valid && trace_copy));

  p_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trace_enable |=> $stable(trace_port));

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cnt
    p_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (hit_count[i*CNT_W +: CNT_W] >= $past(hit_count[i*CNT_W +: CNT_W])));
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((hit_count[i*CNT_W +: CNT_W] - $past(hit_count[i*CNT_W +: CNT_W])) <= CNT_W'(1)));
  end
endmodule

bind trace_filter_port trace_filter_chk #(
  .NUM_CMP(NUM_CMP),
  .CNT_W  (CNT_W),
  .PORT_W (PORT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hdr_ready    (hdr_ready),
  .trace_enable (trace_enable),
  .res_valid    (res_valid),
  .match_vec    (match_vec),
  .trace_copy   (trace_copy),
  .trace_port   (trace_port),
  .route_drop   (route_drop),
  .pw_req       (pw_req),
  .hit_count    (hit_count)
);

// File: tb/sim_trace_filter_port.sv
module sim_trace_filter_port;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int HW = 128;
  localparam int WW = 32;
  localparam int CW = 3;
  localparam int PW = 4;

  localparam logic [127:0] V0 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] M0 = '1;
  localparam logic [127:0] V1 = 128'hA500_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] M1 = 128'hFF00_0000_0000_0000_0000_0000_0000_0000;
  localparam logic [127:0] V2 = 128'h0;
  localparam logic [127:0] M2 = 128'h0;
  localparam logic [127:0] V3 = 128'h0000_0000_0000_0000_0000_0000_DEAD_BEEF;
  localparam logic [127:0] M3 = 128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF;
  localparam logic [127:0] H2 = 128'hA5FF_FFFF_FFFF_FFFF_FFFF_FFFF_DEAD_BEEF;

  // {header, expected match_vec}
  localparam logic [131:0] VEC [8] = '{
    {V0, 4'b0001},
    {H2, 4'b1010},
    {128'hA500_0000_0000_0000_0000_0000_0000_0001, 4'b0010},
    {128'h0, 4'b0000},
    {128'hDEAD_BEEF_0000_0000_0000_0000_0000_0000, 4'b0000},
    {128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211, 4'b0000},
    {128'hA523_4567_89AB_CDEF_FEDC_BA98_DEAD_BEEF, 4'b1010},
    {128'h5A00_0000_0000_0000_0000_0000_DEAD_BEEF, 4'b1000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0, hdr_sop = 1'b0, hdr_last = 1'b0;
  logic [WW-1:0] hdr_data = '0;
  logic hdr_ready;
  logic trace_enable = 1'b0, pw_enable = 1'b0, filter_enable = 1'b0;
  logic [PW-1:0] trace_port_sel = 4'd5;
  logic res_valid, trace_copy, route_drop, pw_req;
  logic [NC-1:0] match_vec;
  logic [PW-1:0] trace_port;
  logic [NC*CW-1:0] hit_count;
  logic [NC*HW-1:0] cmp_value, cmp_mask;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt [NC];

  assign cmp_value = {V3, V2, V1, V0};
  assign cmp_mask  = {M3, M2, M1, M0};

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_filter_port #(.NUM_CMP(NC), .HDR_W(HW), .WORD_W(WW), .CNT_W(CW), .PORT_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_sop(hdr_sop), .hdr_last(hdr_last), .hdr_data(hdr_data),
    .cmp_value(cmp_value), .cmp_mask(cmp_mask), .trace_enable(trace_enable),
    .trace_port_sel(trace_port_sel), .pw_enable(pw_enable), .filter_enable(filter_enable),
    .res_valid(res_valid), .match_vec(match_vec), .trace_copy(trace_copy),
    .trace_port(trace_port), .route_drop(route_drop), .pw_req(pw_req), .hit_count(hit_count)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic beat(input logic [WW-1:0] d, input logic s, input logic l);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_data = d; hdr_sop = s; hdr_last = l;
  endtask

  task automatic stop_and_wait();
    @(negedge clk);
    hdr_valid = 1'b0; hdr_sop = 1'b0; hdr_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_hdr(input logic [127:0] h, input logic with_last);
    for (int b = 0; b < 4; b++)
      beat(h[127-32*b -: 32], b == 0, with_last && b == 3);
  endtask

  task automatic pkt(input logic [127:0] h);
    send_hdr(h, 1'b1);
    stop_and_wait();
  endtask

  task automatic model(input logic [3:0] m);
    for (int i = 0; i < NC; i++)
      if (m[i] && exp_cnt[i] < 7) exp_cnt[i]++;
  endtask

  task automatic chk_counts(input string req);
    for (int i = 0; i < NC; i++)
      chk(req, $sformatf("hit_count[%0d]", i), 32'(hit_count[i*CW +: CW]), 32'(exp_cnt[i]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < NC; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "hdr_ready in reset", 32'(hdr_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    chk("R1", "hdr_ready", 32'(hdr_ready), 1);
    chk("R4", "res_valid idle", 32'(res_valid), 0);
    chk("R4", "match_vec idle", 32'(match_vec), 0);
    chk_counts("R9");
    chk("R10", "trace_port load while disabled", 32'(trace_port), 5);

    trace_enable = 1'b1; pw_enable = 1'b1; filter_enable = 1'b0;
    // table walk: R2 alignment, R3 masks, R11 multiple hits
    for (int v = 0; v < 8; v++) begin
      pkt(VEC[v][131:4]);
      model(VEC[v][3:0]);
      chk("R4", $sformatf("res_valid vec %0d", v), 32'(res_valid), 1);
      chk("R2", $sformatf("match_vec vec %0d", v), 32'(match_vec), 32'(VEC[v][3:0]));
      chk("R6", $sformatf("trace_copy vec %0d", v), 32'(trace_copy), 32'(|VEC[v][3:0]));
      chk("R7", $sformatf("route_drop vec %0d", v), 32'(route_drop), 0);
      chk("R8", $sformatf("pw_req vec %0d", v), 32'(pw_req), 32'(|VEC[v][3:0]));
      @(negedge clk);
      chk("R4", "res_valid one cycle", 32'(res_valid), 0);
      chk("R4", "match held", 32'(match_vec), 32'(VEC[v][3:0]));
    end
    chk_counts("R11");
    chk("R3", "zero-mask counter", 32'(hit_count[2*CW +: CW]), 0);

    // R10 trace port held while enabled
    trace_port_sel = 4'd9;
    repeat (3) @(negedge clk);
    chk("R10", "trace_port held", 32'(trace_port), 5);
    trace_enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "trace_port reloaded", 32'(trace_port), 9);
    trace_enable = 1'b1;

    // R5 short packet, with filter on
    filter_enable = 1'b1;
    beat(32'hA5FF_FFFF, 1'b1, 1'b0);
    beat(32'hFFFF_FFFF, 1'b0, 1'b1);
    stop_and_wait();
    chk("R5", "short res_valid", 32'(res_valid), 1);
    chk("R5", "short match_vec", 32'(match_vec), 0);
    chk("R7", "short route_drop", 32'(route_drop), 1);
    chk("R6", "short trace_copy", 32'(trace_copy), 0);

    // R7 filter with match keeps route
    pkt(H2); model(4'b1010);
    chk("R7", "filter match route_drop", 32'(route_drop), 0);
    chk("R6", "filter match trace_copy", 32'(trace_copy), 1);
    filter_enable = 1'b0;

    // R8 pw disabled
    pw_enable = 1'b0;
    pkt(V0); model(4'b0001);
    chk("R8", "pw_req disabled", 32'(pw_req), 0);
    chk("R6", "trace_copy pw off", 32'(trace_copy), 1);
    pw_enable = 1'b1;

    // R6/R8 tracing disabled
    trace_enable = 1'b0;
    pkt(V0); model(4'b0001);
    chk("R6", "trace_copy trace off", 32'(trace_copy), 0);
    chk("R8", "pw_req trace off", 32'(pw_req), 0);
    chk("R4", "match with trace off", 32'(match_vec), 1);
    trace_enable = 1'b1;

    // R5 beats past the window give no result
    send_hdr(V0, 1'b0);
    stop_and_wait(); model(4'b0001);
    chk("R5", "window result", 32'(res_valid), 1);
    beat(32'hA5A5_A5A5, 1'b0, 1'b0);
    beat(32'hDEAD_BEEF, 1'b0, 1'b1);
    stop_and_wait();
    chk("R5", "trailing beats no result", 32'(res_valid), 0);
    chk("R5", "trailing beats match held", 32'(match_vec), 1);

    // R5 restart on new start-of-packet
    beat(32'h0123_4567, 1'b1, 1'b0);
    beat(32'h89AB_CDEF, 1'b0, 1'b0);
    pkt(H2); model(4'b1010);
    chk("R5", "restart match_vec", 32'(match_vec), 32'b1010);
    chk_counts("R5");

    // R9 saturation
    for (int k = 0; k < 6; k++) begin
      pkt(H2); model(4'b1010);
    end
    chk("R9", "sat counter 1", 32'(hit_count[1*CW +: CW]), 7);
    chk("R9", "sat counter 3", 32'(hit_count[3*CW +: CW]), 7);
    chk_counts("R9");
    summary();
  end
endmodule